// File: doc/BRIEF.md
# Load-Step Stage Gating Controller

This controller drives the enable mask of an eight-stage interleaved switched-capacitor converter. Each stage runs on its own phase of the switching clock, so the stage that turns on or off sets when its input-current spike appears. An upstream load monitor raises a one-cycle request when demand rises or falls. The controller then turns on exactly one idle stage, or turns off exactly one running stage. The stage is picked by a free-running pseudo-random sequence rather than in a fixed order, which makes the timing of the supply-side current signature unpredictable.

While no request arrives the mask does not change. A request that cannot be met is dropped and a one-cycle flag reports it. That covers adding a stage when every stage already runs, or removing one when only a single stage is left. Simultaneous rise and fall requests cancel each other. The reset pattern of the mask is a parameter.

Top module: `stage_gate_ctrl`

## Requirements
- R1: While rst_ni is low and after it rises, before any request: mask_o equals the INIT_MASK parameter (default 8'h55), count_o equals its population count, flag_o is 0, and the generator state equals LFSR_SEED (default 16'hACE1).
- R2: A cycle with inc_i=1 and dec_i=0 while fewer than 8 stages run sets exactly one mask bit that was 0 and clears none.
- R3: A cycle with dec_i=1 and inc_i=0 while 2 or more stages run clears exactly one mask bit that was 1 and sets none.
- R4: A cycle with neither request leaves mask_o unchanged and leaves flag_o 0.
- R5: A cycle with both inc_i and dec_i high leaves mask_o unchanged and leaves flag_o 0.
- R6: An increment while all 8 stages run leaves mask_o unchanged and sets flag_o for the following cycle only, unless the next request is ignored as well.
- R7: A decrement while 1 or 0 stages run leaves mask_o unchanged and sets flag_o for the following cycle only, unless the next request is ignored as well.
- R8: The generator is a 16-bit shift register. Its next state is {s[14:0], s[15]^s[13]^s[12]^s[10]}. It advances on every clock edge after reset, whether or not a request is present.
- R9: The stage that changes is found by starting at index s[2:0] of the generator state held at the request edge. The search scans upward modulo 8 to the first eligible stage: a 0 bit for an increment, a 1 bit for a decrement.
- R10: count_o is a 4-bit value equal to the number of 1 bits in mask_o.
- R11: mask_o, count_o and flag_o all take their new values at the same clock edge that samples the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| inc_i | input | 1 | Demand rise: add one stage |
| dec_i | input | 1 | Demand fall: remove one stage |
| mask_o | output | 8 | Per-stage enable, bit n drives stage n |
| count_o | output | 4 | Number of enabled stages |
| flag_o | output | 1 | Previous request was ignored |

## Verification
Every result is due one edge after the request. The mask, count and flag are all registered or derived from registers at the edge that samples the request. The driver sets the inputs on the falling edge and pushes the expected mask, count and flag into a queue. The monitor pops that entry two nanoseconds after the next rising edge, so each comparison lands in the cycle in which the design's outputs have settled. The expected stage index comes from a bench model of the generator. That model is reset with the design and steps on every rising edge, so idle cycles shift later choices just as they do in the design.

// File: rtl/stage_gate_pkg.sv
package stage_gate_pkg;
  typedef enum logic [1:0] {
    OP_HOLD   = 2'd0,
    OP_ADD    = 2'd1,
    OP_DROP   = 2'd2,
    OP_REJECT = 2'd3
  } gate_op_e;
endpackage

// File: rtl/stage_gate_lfsr.sv
module stage_gate_lfsr #(
  parameter int unsigned     WIDTH = 16,
  parameter logic [WIDTH-1:0] SEED = 16'hACE1,
  parameter logic [WIDTH-1:0] TAPS = 16'hB400
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [WIDTH-1:0] state_o
);
  logic [WIDTH-1:0] state_q;
  logic             fb;

  assign fb = ^(state_q & TAPS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEED;
    else         state_q <= {state_q[WIDTH-2:0], fb};
  end

  assign state_o = state_q;
endmodule

// File: rtl/stage_gate_pick.sv
module stage_gate_pick #(
  parameter int unsigned N     = 8,
  parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     elig_i,
  input  logic [IDX_W-1:0] start_i,
  output logic [N-1:0]     sel_o,
  output logic             found_o
);
  // circular upward search from start_i
  always_comb begin
    int base;
    int idx;
    sel_o   = '0;
    found_o = 1'b0;
    base    = int'(start_i) % int'(N);
    for (int k = 0; k < int'(N); k++) begin
      idx = (base + k) % int'(N);
      if (!found_o && elig_i[idx]) begin
        sel_o[idx] = 1'b1;
        found_o    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/stage_gate_ctrl.sv
module stage_gate_ctrl
  import stage_gate_pkg::*;
#(
  parameter int unsigned            NUM_STAGES = 8,
  parameter int unsigned            LFSR_W     = 16,
  parameter logic [LFSR_W-1:0]      LFSR_SEED  = 16'hACE1,
  parameter logic [LFSR_W-1:0]      LFSR_TAPS  = 16'hB400,
  parameter logic [NUM_STAGES-1:0]  INIT_MASK  = 8'h55,
  localparam int unsigned           IDX_W      = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1,
  localparam int unsigned           CNT_W      = $clog2(NUM_STAGES + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  inc_i,
  input  logic                  dec_i,
  output logic [NUM_STAGES-1:0] mask_o,
  output logic [CNT_W-1:0]      count_o,
  output logic                  flag_o
);
  logic [LFSR_W-1:0]     rnd;
  logic [NUM_STAGES-1:0] mask_q, mask_d, elig, sel;
  logic                  found;
  logic [CNT_W-1:0]      cnt;
  logic                  flag_q;
  gate_op_e              op;

  stage_gate_lfsr #(
    .WIDTH (LFSR_W),
    .SEED  (LFSR_SEED),
    .TAPS  (LFSR_TAPS)
  ) u_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .state_o (rnd)
  );

  always_comb begin
    cnt = '0;
    for (int i = 0; i < int'(NUM_STAGES); i++) cnt = cnt + CNT_W'(mask_q[i]);
  end

  always_comb begin
    op = OP_HOLD;
    if (inc_i && !dec_i)      op = (cnt == CNT_W'(NUM_STAGES)) ? OP_REJECT : OP_ADD;
    else if (dec_i && !inc_i) op = (cnt <= CNT_W'(1))          ? OP_REJECT : OP_DROP;
  end

  assign elig = (op == OP_ADD) ? ~mask_q : mask_q;

  stage_gate_pick #(
    .N     (NUM_STAGES),
    .IDX_W (IDX_W)
  ) u_pick (
    .elig_i  (elig),
    .start_i (rnd[IDX_W-1:0]),
    .sel_o   (sel),
    .found_o (found)
  );

  always_comb begin
    mask_d = mask_q;
    unique case (op)
      OP_ADD:  if (found) mask_d = mask_q | sel;
      OP_DROP: if (found) mask_d = mask_q & ~sel;
      default: mask_d = mask_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= INIT_MASK;
      flag_q <= 1'b0;
    end else begin
      mask_q <= mask_d;
      flag_q <= (op == OP_REJECT);
    end
  end

  assign mask_o  = mask_q;
  assign count_o = cnt;
  assign flag_o  = flag_q;
endmodule

// File: rtl/stage_gate_ctrl_chk.sv
module stage_gate_ctrl_chk #(
  parameter int unsigned NUM_STAGES = 8,
  localparam int unsigned CNT_W = $clog2(NUM_STAGES + 1)
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  inc_i,
  input logic                  dec_i,
  input logic [NUM_STAGES-1:0] mask_o,
  input logic [CNT_W-1:0]      count_o,
  input logic                  flag_o
);
  p_add_one_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !dec_i && $countones(mask_o) < NUM_STAGES) |=>
      ($countones(mask_o) == $countones($past(mask_o)) + 1) &&
      ((mask_o & $past(mask_o)) == $past(mask_o)) && !flag_o);

  p_drop_one_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !inc_i && $countones(mask_o) > 1) |=>
      ($countones(mask_o) + 1 == $countones($past(mask_o))) &&
      ((mask_o | $past(mask_o)) == $past(mask_o)) && !flag_o);

  p_idle_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !dec_i) |=> $stable(mask_o) && !flag_o);

  p_cancel_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && dec_i) |=> $stable(mask_o) && !flag_o);

  p_full_reject_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !dec_i && $countones(mask_o) == NUM_STAGES) |=> $stable(mask_o) && flag_o);

  p_low_reject_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !inc_i && $countones(mask_o) <= 1) |=> $stable(mask_o) && flag_o);

  p_count_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(mask_o) |-> $stable(count_o));
endmodule

bind stage_gate_ctrl stage_gate_ctrl_chk #(.NUM_STAGES(NUM_STAGES)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .inc_i   (inc_i),
  .dec_i   (dec_i),
  .mask_o  (mask_o),
  .count_o (count_o),
  .flag_o  (flag_o)
);

// File: tb/stage_gate_ctrl_tb_top.sv
`timescale 1ns/1ps
module stage_gate_ctrl_tb_top;
  localparam logic [15:0] SEED = 16'hACE1;
  localparam logic [7:0]  INIT = 8'h55;

  typedef struct {
    logic [7:0] mask;
    logic [3:0] count;
    logic       flag;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       inc_r = 1'b0, dec_r = 1'b0;
  logic [7:0] mask;
  logic [3:0] count;
  logic       flag;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  exp_t q[$];
  logic [15:0] m_lfsr;
  logic [7:0]  mdl_mask;

  always #5 clk = ~clk;

  stage_gate_ctrl dut_i (
    .clk_i   (clk),
    .rst_ni  (rst_ni),
    .inc_i   (inc_r),
    .dec_i   (dec_r),
    .mask_o  (mask),
    .count_o (count),
    .flag_o  (flag)
  );

  // R8 generator model
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) m_lfsr <= SEED;
    else         m_lfsr <= {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
  end

  function automatic logic [7:0] pick(logic [7:0] elig, logic [2:0] start);
    for (int k = 0; k < 8; k++) begin
      int j;
      j = (int'(start) + k) % 8;
      if (elig[j]) return 8'(1) << j;
    end
    return 8'h00;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(bit inc, bit dec);
    exp_t e;
    int   c;
    @(negedge clk);
    inc_r = inc;
    dec_r = dec;
    c = $countones(mdl_mask);
    e.flag = 1'b0;
    if (inc && dec) e.tag = "R5";
    else if (inc) begin
      if (c == 8) begin e.flag = 1'b1; e.tag = "R6"; end
      else begin mdl_mask = mdl_mask | pick(~mdl_mask, m_lfsr[2:0]); e.tag = "R2 R8 R9 R11"; end
    end else if (dec) begin
      if (c <= 1) begin e.flag = 1'b1; e.tag = "R7"; end
      else begin mdl_mask = mdl_mask & ~pick(mdl_mask, m_lfsr[2:0]); e.tag = "R3 R8 R9 R11"; end
    end else e.tag = "R4";
    e.mask  = mdl_mask;
    e.count = 4'($countones(mdl_mask));
    q.push_back(e);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(e.tag, "mask", int'(mask), int'(e.mask));
        chk("R10", "count", int'(count), int'(e.count));
        chk(e.tag, "flag", int'(flag), int'(e.flag));
      end
    end
  end

  initial begin
    mdl_mask = INIT;
    #12;
    chk("R1", "mask in reset", int'(mask), int'(INIT));
    chk("R1", "flag in reset", int'(flag), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    chk("R1", "mask after reset", int'(mask), int'(INIT));
    chk("R1", "count after reset", int'(count), 4);
    chk("R1", "flag after reset", int'(flag), 0);
    repeat (3) step(0, 0);
    repeat (4) step(1, 0);   // reach full
    step(1, 0);              // R6 reject
    step(1, 0);              // R6 again
    step(0, 0);              // flag clears
    step(1, 1);              // R5
    repeat (7) step(0, 1);   // down to one
    step(0, 1);              // R7 reject
    step(0, 0);
    step(1, 1);
    for (int n = 0; n < 400; n++) begin
      int r;
      r = int'($urandom_range(0, 9));
      if (r < 4)      step(1, 0);
      else if (r < 8) step(0, 1);
      else if (r < 9) step(1, 1);
      else            step(0, 0);
    end
    @(negedge clk);
    inc_r = 1'b0;
    dec_r = 1'b0;
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule